// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer with Predicated Branches

This block produces the fetch address for a deep, wide-issue pipeline in which every control transfer is a delayed branch. Several branch-capable units may each raise a branch request with a target. A request counts only when its predicate holds. The predicate is a test of a general register against zero, and an invert bit selects which sense of the test is used. Once a branch is accepted, the sequencer keeps fetching sequential addresses for a fixed number of delay slots. Only after those slots does it redirect fetch to the target.

While a redirect is outstanding, the sequencer withholds permission to accept interrupts. Without this, an interrupt could split the delay-slot sequence. Two units branching in the same cycle has no defined outcome. The sequencer treats it as an error: it latches a sticky flag and follows the lowest-numbered unit's target. A stall input freezes the whole sequence, and branch requests are not sampled while it is high.

Top module: `dslot_seq`

## Requirements
- R1: After reset `fetch_pc` is 0, `irq_en` is 1, `dual_err` is 0 and no redirect is outstanding.
- R2: In a cycle without stall, with no outstanding redirect and no accepted branch, `fetch_pc` advances by exactly 1 at the next edge.
- R3: After a branch is accepted in a non-stalled cycle, the next DELAY_SLOTS (default 5) non-stalled cycles present the sequential addresses following the current one. The cycle after those presents the target.
- R4: Unit i's request (`br_req[i]`) is accepted when the register slice `pred_val[i*REG_W +: REG_W]` is nonzero XOR `pred_inv[i]` is 1. With `pred_inv[i]`=0 the branch needs a nonzero register, and with 1 it needs a zero register. A request whose predicate fails leaves the sequential flow unchanged.
- R5: `irq_en` is 0 in any cycle that accepts a branch and in every cycle while delay slots remain; otherwise it is 1. `irq_take` equals `irq_req & irq_en & ~stall`.
- R6: A branch accepted while an earlier redirect is outstanding restarts the full delay-slot count with its own target, and the earlier target is never fetched.
- R7: When two or more units have accepted branches in the same non-stalled cycle, `dual_err` rises at the next edge and stays 1 until reset. The target of the lowest-numbered accepting unit is the one used (unit 0 over unit 1, with targets at `br_target[i*PC_W +: PC_W]`).
- R8: While `stall` is 1, `fetch_pc`, the remaining-slot count and `dual_err` hold. Branch requests in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes sequencing for the cycle |
| br_req | input | N_UNITS | Branch request per unit |
| br_target | input | N_UNITS*PC_W | Branch target per unit, unit i in slice i |
| pred_val | input | N_UNITS*REG_W | Predicate register value per unit |
| pred_inv | input | N_UNITS | Predicate invert per unit (1 = branch on zero) |
| irq_req | input | 1 | Interrupt request |
| fetch_pc | output | PC_W | Current fetch address |
| irq_en | output | 1 | Interrupt acceptance permitted |
| irq_take | output | 1 | Interrupt accepted this cycle |
| dual_err | output | 1 | Sticky flag for simultaneous branches |

## Verification
The bench builds the block with its defaults: two branch units, 16-bit addresses, 32-bit predicate registers and five delay slots. With two units, both the ordering rule and the dual-branch conflict can be exercised. Five slots keep each complete window short enough for a table to trace it address by address. The table covers a stall inside a window, a restart inside a window, and predicates on both zero and nonzero registers with both invert settings. A mid-run reset then shows that state returns to its initial values.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  // Predicate test: register nonzero, optionally inverted to branch-on-zero.
  function automatic logic pred_hit(input logic nonzero, input logic inv);
    return nonzero ^ inv;
  endfunction

  // Sequential fetch step: one fetch packet per cycle.
  function automatic logic [63:0] seq_next(input logic [63:0] pc);
    return pc + 64'd1;
  endfunction

  typedef enum logic [1:0] {
    ST_SEQ    = 2'd0,
    ST_SLOTS  = 2'd1,
    ST_REDIR  = 2'd2
  } seq_evt_e;

endpackage

// File: rtl/dslot_pred.sv
module dslot_pred #(
  parameter int REG_W = 32
) (
  input  logic             req,
  input  logic [REG_W-1:0] val,
  input  logic             inv,
  input  logic             stall,
  output logic             take
);
  import dslot_pkg::*;

  logic nonzero;

  assign nonzero = |val;
  assign take    = req && !stall && pred_hit(nonzero, inv);

endmodule

// File: rtl/dslot_pick.sv
module dslot_pick #(
  parameter int N_UNITS = 2,
  parameter int PC_W    = 16
) (
  input  logic [N_UNITS-1:0]      take,
  input  logic [N_UNITS*PC_W-1:0] targets,
  output logic                    any_take,
  output logic                    multi_take,
  output logic [PC_W-1:0]         sel_tgt
);
  localparam int CW = $clog2(N_UNITS + 1);

  logic [CW-1:0] n_take;

  always_comb begin
    n_take = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      n_take = n_take + CW'(take[i]);
    end
  end

  // Lowest-numbered accepting unit wins: scan from the top down.
  always_comb begin
    sel_tgt = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (take[i]) sel_tgt = targets[i*PC_W +: PC_W];
    end
  end

  assign any_take   = |take;
  assign multi_take = (n_take > CW'(1));

endmodule

// File: rtl/dslot_core.sv
module dslot_core #(
  parameter int PC_W        = 16,
  parameter int DELAY_SLOTS = 5,
  parameter int CNT_W       = $clog2(DELAY_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             any_take,
  input  logic             multi_take,
  input  logic [PC_W-1:0]  sel_tgt,
  output logic [PC_W-1:0]  pc_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [PC_W-1:0]  tgt_q,
  output logic             err_q,
  output dslot_pkg::seq_evt_e evt
);
  import dslot_pkg::*;

  localparam logic [CNT_W-1:0] SLOTS = CNT_W'(DELAY_SLOTS);

  logic            slot_last;
  logic            pending;
  logic [PC_W-1:0] pc_inc;
  logic [63:0]     pc_wide;

  assign pending   = (cnt_q != '0);
  assign slot_last = (cnt_q == CNT_W'(1));
  assign pc_wide   = seq_next(64'(pc_q));
  assign pc_inc    = pc_wide[PC_W-1:0];

  always_comb begin
    if (!pending || any_take) evt = ST_SEQ;
    else if (slot_last)       evt = ST_REDIR;
    else                      evt = ST_SLOTS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
      tgt_q <= '0;
      err_q <= 1'b0;
    end else if (!stall) begin
      err_q <= err_q | multi_take;
      if (any_take) begin
        tgt_q <= sel_tgt;
        cnt_q <= SLOTS;
        pc_q  <= pc_inc;
      end else if (evt == ST_REDIR) begin
        cnt_q <= '0;
        pc_q  <= tgt_q;
      end else begin
        pc_q <= pc_inc;
        if (pending) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dslot_seq.sv
module dslot_seq #(
  parameter int N_UNITS     = 2,
  parameter int PC_W        = 16,
  parameter int REG_W       = 32,
  parameter int DELAY_SLOTS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stall,
  input  logic [N_UNITS-1:0]       br_req,
  input  logic [N_UNITS*PC_W-1:0]  br_target,
  input  logic [N_UNITS*REG_W-1:0] pred_val,
  input  logic [N_UNITS-1:0]       pred_inv,
  input  logic                     irq_req,
  output logic [PC_W-1:0]          fetch_pc,
  output logic                     irq_en,
  output logic                     irq_take,
  output logic                     dual_err
);
  localparam int CNT_W = $clog2(DELAY_SLOTS + 1);

  logic [N_UNITS-1:0] unit_take;
  logic               any_take;
  logic               multi_take;
  logic [PC_W-1:0]    sel_tgt;
  logic [CNT_W-1:0]   slot_cnt;
  logic [PC_W-1:0]    slot_tgt;
  dslot_pkg::seq_evt_e seq_evt;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_pred
    dslot_pred #(.REG_W(REG_W)) pred_i (
      .req   (br_req[g]),
      .val   (pred_val[g*REG_W +: REG_W]),
      .inv   (pred_inv[g]),
      .stall (stall),
      .take  (unit_take[g])
    );
  end

  dslot_pick #(.N_UNITS(N_UNITS), .PC_W(PC_W)) pick_i (
    .take       (unit_take),
    .targets    (br_target),
    .any_take   (any_take),
    .multi_take (multi_take),
    .sel_tgt    (sel_tgt)
  );

  dslot_core #(.PC_W(PC_W), .DELAY_SLOTS(DELAY_SLOTS), .CNT_W(CNT_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .any_take   (any_take),
    .multi_take (multi_take),
    .sel_tgt    (sel_tgt),
    .pc_q       (fetch_pc),
    .cnt_q      (slot_cnt),
    .tgt_q      (slot_tgt),
    .err_q      (dual_err),
    .evt        (seq_evt)
  );

  assign irq_en   = (slot_cnt == '0) && !any_take;
  assign irq_take = irq_req && irq_en && !stall;

endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             any_take,
  input logic             multi_take,
  input logic [CNT_W-1:0] slot_cnt,
  input logic [PC_W-1:0]  slot_tgt,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             irq_en,
  input logic             irq_take,
  input logic             dual_err
);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && slot_cnt == '0 && !any_take) |=> fetch_pc == PC_W'($past(fetch_pc) + 1'b1));

  // R3
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && slot_cnt == CNT_W'(1) && !any_take) |=> fetch_pc == $past(slot_tgt));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt != '0) |-> !irq_en);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_en && !stall));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual_err |=> dual_err);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_take |=> dual_err);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(slot_cnt)));

endmodule

bind dslot_seq dslot_seq_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .any_take   (any_take),
  .multi_take (multi_take),
  .slot_cnt   (slot_cnt),
  .slot_tgt   (slot_tgt),
  .fetch_pc   (fetch_pc),
  .irq_en     (irq_en),
  .irq_take   (irq_take),
  .dual_err   (dual_err)
);

// File: tb/dslot_seq_tb_top.sv
module dslot_seq_tb_top;

  localparam int NU = 2;
  localparam int PW = 16;
  localparam int RW = 32;

  typedef struct packed {
    logic          stall;
    logic [1:0]    req;
    logic [15:0]   t0;
    logic [15:0]   t1;
    logic [31:0]   p0;
    logic [31:0]   p1;
    logic [1:0]    inv;
    logic          irq;
    logic [15:0]   e_pc;
    logic          e_ie;
    logic          e_take;
    logic          e_err;
  } row_t;

  function automatic row_t mk(input logic st, input logic [1:0] rq,
                              input logic [15:0] a0, input logic [15:0] a1,
                              input logic [31:0] v0, input logic [31:0] v1,
                              input logic [1:0] iv, input logic ir,
                              input logic [15:0] pc, input logic ie,
                              input logic tk, input logic er);
    row_t r;
    r = '{st, rq, a0, a1, v0, v1, iv, ir, pc, ie, tk, er};
    return r;
  endfunction

  // Expected values describe the state seen during the row's cycle.
  localparam int NROWS = 29;
  localparam row_t TBL [NROWS] = '{
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0000, 1, 0, 0),   // 0  R1 reset state
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 1, 16'h0001, 1, 1, 0),   // 1  R2 R5
    mk(0, 2'b01, 16'h0100, 0, 5, 0, 2'b00, 1, 16'h0002, 0, 0, 0), // 2 R4 take u0
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0003, 0, 0, 0),   // 3  R3 slot1
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0004, 0, 0, 0),   // 4  slot2
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0005, 0, 0, 0),   // 5  slot3
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0006, 0, 0, 0),   // 6  slot4
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 1, 16'h0007, 0, 0, 0),   // 7  slot5, R5 masked
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0100, 1, 0, 0),   // 8  R3 target
    mk(0, 2'b10, 0, 16'h0900, 0, 0, 2'b00, 0, 16'h0101, 1, 0, 0), // 9 R4 pred false
    mk(0, 2'b10, 0, 16'h0200, 0, 0, 2'b10, 0, 16'h0102, 0, 0, 0), // 10 R4 inv, zero
    mk(1, 2'b01, 16'h0A00, 0, 1, 0, 2'b00, 1, 16'h0103, 0, 0, 0), // 11 R8 stall
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 1, 16'h0103, 0, 0, 0),   // 12 R8 held
    mk(0, 2'b01, 16'h0300, 0, 7, 0, 2'b00, 0, 16'h0104, 0, 0, 0), // 13 R6 restart
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0105, 0, 0, 0),   // 14
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0106, 0, 0, 0),   // 15
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0107, 0, 0, 0),   // 16
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0108, 0, 0, 0),   // 17
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0109, 0, 0, 0),   // 18 R6 no 0x200
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 1, 16'h0300, 1, 1, 0),   // 19 R6 new target
    mk(0, 2'b11, 16'h0400, 16'h0500, 3, 9, 2'b00, 0, 16'h0301, 0, 0, 0), // 20 R7
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0302, 0, 0, 1),   // 21 R7 flag
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0303, 0, 0, 1),   // 22
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0304, 0, 0, 1),   // 23
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0305, 0, 0, 1),   // 24
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0306, 0, 0, 1),   // 25
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0400, 1, 0, 1),   // 26 R7 unit0 wins
    mk(1, 2'b01, 16'h0B00, 0, 1, 0, 2'b00, 1, 16'h0401, 1, 0, 1), // 27 R8 ignored
    mk(0, 2'b00, 0, 0, 0, 0, 2'b00, 0, 16'h0401, 1, 0, 1)    // 28 R8 no redirect
  };

  logic             clk;
  logic             rst_n;
  logic             stall;
  logic [NU-1:0]    br_req;
  logic [NU*PW-1:0] br_target;
  logic [NU*RW-1:0] pred_val;
  logic [NU-1:0]    pred_inv;
  logic             irq_req;
  logic [PW-1:0]    fetch_pc;
  logic             irq_en;
  logic             irq_take;
  logic             dual_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dslot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .br_req(br_req),
    .br_target(br_target), .pred_val(pred_val), .pred_inv(pred_inv),
    .irq_req(irq_req), .fetch_pc(fetch_pc), .irq_en(irq_en),
    .irq_take(irq_take), .dual_err(dual_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    stall = 0; br_req = '0; br_target = '0; pred_val = '0; pred_inv = '0; irq_req = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NROWS; i++) begin
      if (i != 0) @(negedge clk);
      stall     = TBL[i].stall;
      br_req    = TBL[i].req;
      br_target = {TBL[i].t1, TBL[i].t0};
      pred_val  = {TBL[i].p1, TBL[i].p0};
      pred_inv  = TBL[i].inv;
      irq_req   = TBL[i].irq;
      #1;
      chk($sformatf("R3/R6 pc row %0d", i), 32'(fetch_pc), 32'(TBL[i].e_pc));
      chk($sformatf("R5 irq_en row %0d", i), 32'(irq_en), 32'(TBL[i].e_ie));
      chk($sformatf("R5 irq_take row %0d", i), 32'(irq_take), 32'(TBL[i].e_take));
      chk($sformatf("R7 dual_err row %0d", i), 32'(dual_err), 32'(TBL[i].e_err));
    end

    // R1: mid-run reset brings everything back to the initial state.
    @(negedge clk);
    idle_inputs();
    br_req = 2'b01; br_target = {16'h0, 16'h0C00}; pred_val = {32'h0, 32'h1};
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 pc after reset", 32'(fetch_pc), 32'h0);
    chk("R1 irq_en after reset", 32'(irq_en), 32'h1);
    chk("R1 dual_err after reset", 32'(dual_err), 32'h0);

    // R1: no redirect survives the reset; six plain steps reach 6.
    repeat (6) @(negedge clk);
    #1;
    chk("R1 R2 no pending redirect", 32'(fetch_pc), 32'h6);

    // R4: unit 1 inverted with a nonzero register does not branch.
    br_req = 2'b10; br_target = {16'h0D00, 16'h0}; pred_val = {32'h4, 32'h0}; pred_inv = 2'b10;
    #1;
    chk("R4 inverted nonzero not taken", 32'(irq_en), 32'h1);
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R4 pc sequential", 32'(fetch_pc), 32'h7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule